// File: doc/BRIEF.md
# Two-Stage Overflow Watchdog Timer

This block is a watchdog for a system that must be reset when its software stops responding. Software programs a 12-bit period value and sets an enable bit. A counting core on a free-running oscillator clock then measures elapsed time, with one period lasting `(N + 1) * 2^PRESCALE_LOG2` oscillator cycles. When the first period ends without service, the block raises an interrupt. If a second period also ends before software services the timer, the block asserts a reset request. That request stays high until the block itself is reset.

Software services the timer by writing a one to bit 0 of the service register. This drops the pending interrupt at once. It also restarts the elapsed count, so the two-period sequence begins again.

The register port runs on a bus clock and is a single-cycle select/write/address/data interface with no wait states. Settings written from the bus reach the oscillator domain through toggle-synchronised channels, so they take effect after a fixed, short delay. The block has no streaming data path, so there is no valid/ready back-pressure; every pin is a plain level.

Top module: `wdt_twostage`

## Requirements
- R1: After `rst_n`, `irq` and `rst_req` are low. Word reads of offsets 0x0 (control), 0x4 (period), 0x8 (count) and 0xC (service) all return zero.
- R2: Only bits [31:20] of a write to offset 0x4 are kept; they hold the period field N. Reading offset 0x4 returns N in bits [31:20], and bits [19:0] read as zero.
- R3: Bit 0 of offset 0x0 enables counting. While it is 0 the elapsed count holds its value, and a read of offset 0x8 returns that held count.
- R4: One period lasts `(N + 1) * 2^PRESCALE_LOG2` oscillator cycles. The first overflow sets `irq` and bit 0 of offset 0xC. Both become visible at the third rising bus edge after the oscillator edge at which the count wraps.
- R5: An overflow that arrives while `irq` is already pending sets `rst_req`. `rst_req` then stays high until `rst_n` is applied, whatever is written.
- R6: A write to offset 0xC with bit 0 set clears `irq` at the bus edge that captures the write. It also zeroes the count at the third rising oscillator edge after that bus edge. A write to 0xC with bit 0 clear has no effect. If an overflow event reaches the bus side in the same cycle as the service write, `irq` stays set and no reset is requested.
- R7: A write of the value zero to offset 0x8 zeroes the count at the third rising oscillator edge after capture. A nonzero write to offset 0x8 is ignored.
- R8: Writes to offsets 0x0, 0x4 and 0x8 take effect at the third rising oscillator edge after the bus edge that captures them. This is inside the allowed budget of 6 oscillator cycles plus 9 bus cycles. Until that edge, counting uses the previous settings. Writes that go through the same channel must be at least four oscillator cycles apart.
- R9: A count read is a two-bus-cycle synchronised snapshot of the oscillator-domain count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock |
| oclk | input | 1 | Oscillator clock driving the counting core |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| psel | input | 1 | Access select |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 4 | Byte address; only aligned word offsets respond |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, combinational from `paddr` |
| irq | output | 1 | First-overflow interrupt (bus domain) |
| rst_req | output | 1 | Sticky reset request after the second overflow (bus domain) |

## Verification
Several corner cases are targeted, each with the fault it would expose:

- **Disabled count.** The count is read back while disabled and must stay frozen. A core that keeps counting, or one that ignores the enable through the crossing, returns a changed value.
- **Period register field.** An all-ones write to the period register must read back only the 12-bit field; a design with a wrong field position or mask shows stray low bits.
- **Service writes.** A service write with bit 0 clear must leave `irq` set. Regular servicing must hold off `rst_req` indefinitely. A design that reads the wrong bit, or fails to restart the count, either drops the interrupt or asserts reset too early.
- **Sticky reset request.** Once `rst_req` is high, disabling and servicing the block must not lower it.
- **Crossing latency.** A reference model tracks the exact crossing latency in both directions and compares `irq` and `rst_req` on every bus cycle. An extra or missing synchroniser stage shifts an edge by a cycle and is reported.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Word index taken from paddr[3:2]
  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_PERIOD = 2'd1,
    REG_COUNT  = 2'd2,
    REG_KICK   = 2'd3
  } wdt_reg_e;
endpackage

// File: rtl/wdt_xfer.sv
// Toggle channel: a held payload plus a toggle that a three-stage chain
// in the destination domain turns into a one-cycle fire pulse.
module wdt_xfer #(
  parameter int W = 1
) (
  input  logic         rst_n,
  input  logic         src_clk,
  input  logic         src_load,
  input  logic [W-1:0] src_data,
  input  logic         dst_clk,
  output logic         dst_fire,
  output logic [W-1:0] dst_data
);
  logic [W-1:0] hold_q;
  logic         tgl_q;
  logic [2:0]   sy_q;

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      tgl_q  <= 1'b0;
    end else if (src_load) begin
      hold_q <= src_data;
      tgl_q  <= ~tgl_q;
    end
  end

  always_ff @(posedge dst_clk or negedge rst_n) begin
    if (!rst_n) sy_q <= '0;
    else        sy_q <= {sy_q[1:0], tgl_q};
  end

  assign dst_fire = sy_q[1] ^ sy_q[2];
  assign dst_data = hold_q;   // quasi-static once the toggle is seen

  // R8: loads spaced as required never produce back-to-back fires
  a_r8_spaced_updates: assert property (@(posedge dst_clk) disable iff (!rst_n)
    dst_fire |=> !dst_fire);
endmodule

// File: rtl/wdt_osc_core.sv
// Oscillator-domain counter: prescaled period count, wrap toggle and
// Gray-coded copy of the count for the bus side.
module wdt_osc_core #(
  parameter int PERIOD_W = 12,
  parameter int PRE      = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_fire,
  input  logic                    cfg_en,
  input  logic [PERIOD_W-1:0]     cfg_period,
  input  logic                    zero_fire,
  input  logic                    zero_do,
  output logic                    ovf_tgl,
  output logic [PERIOD_W+PRE-1:0] cnt_gray
);
  localparam int CNT_W = PERIOD_W + PRE;

  logic                en_q;
  logic [PERIOD_W-1:0] per_q;
  logic [CNT_W-1:0]    cnt_q, cnt_nx, limit;
  logic                wrap, zap;

  // (N+1)*2^PRE - 1 is N followed by PRE ones
  assign limit = {per_q, {PRE{1'b1}}};
  assign wrap  = en_q && (cnt_q == limit);
  assign zap   = zero_fire && zero_do;

  always_comb begin
    cnt_nx = cnt_q;
    if (en_q) cnt_nx = wrap ? '0 : cnt_q + CNT_W'(1);
    if (zap)  cnt_nx = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      per_q    <= '0;
      cnt_q    <= '0;
      ovf_tgl  <= 1'b0;
      cnt_gray <= '0;
    end else begin
      cnt_q    <= cnt_nx;
      cnt_gray <= cnt_nx ^ (cnt_nx >> 1);
      if (wrap) ovf_tgl <= ~ovf_tgl;
      if (cfg_fire) begin
        en_q  <= cfg_en;
        per_q <= cfg_period;
      end
    end
  end

  // R3: a disabled core with nothing arriving holds its count
  a_r3_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !cfg_fire && !zap) |=> $stable(cnt_q));
  // R4: reaching the limit wraps to zero and flips the overflow toggle
  a_r4_wrap_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && cnt_q == limit) |=> (cnt_q == '0 && ovf_tgl != $past(ovf_tgl)));
  // R7: an accepted zero request leaves the count at zero
  a_r7_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
    zap |=> (cnt_q == '0));
endmodule

// File: rtl/wdt_stage.sv
// Bus-domain overflow staging: first event -> irq, second -> sticky rst_req.
module wdt_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_tgl_in,
  input  logic kick,
  output logic irq,
  output logic rst_req
);
  logic [2:0] sy_q;
  logic       evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sy_q <= '0;
    else        sy_q <= {sy_q[1:0], ovf_tgl_in};
  end
  assign evt = sy_q[1] ^ sy_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq     <= 1'b0;
      rst_req <= 1'b0;
    end else if (evt) begin
      // a service in the same cycle is taken as coming first
      if (irq && !kick) rst_req <= 1'b1;
      irq <= 1'b1;
    end else if (kick) begin
      irq <= 1'b0;
    end
  end

  // R5: the reset request never falls without rst_n
  a_r5_rst_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);
  // R5: reset is only requested on top of a pending interrupt
  a_r5_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(irq));
  // R4: irq only rises on a synchronised overflow event
  a_r4_irq_from_event: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(evt));
  // R6: a service with no competing event drops irq
  a_r6_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (kick && !evt) |=> !irq);
endmodule

// File: rtl/wdt_twostage.sv
module wdt_twostage
  import wdt_pkg::*;
#(
  parameter int PERIOD_W      = 12,
  parameter int PRESCALE_LOG2 = 20,
  parameter int DATA_W        = 32
) (
  input  logic              bclk,
  input  logic              oclk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              pwrite,
  input  logic [3:0]        paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              irq,
  output logic              rst_req
);
  localparam int CNT_W = PERIOD_W + PRESCALE_LOG2;
  localparam int CFG_W = PERIOD_W + 1;
  localparam int PLSB  = DATA_W - PERIOD_W;

  logic          aligned, wr;
  wdt_reg_e      rsel;
  logic          wr_ctrl, wr_per, wr_cnt, kick;
  logic          en_sh, en_nx;
  logic [PERIOD_W-1:0] per_sh, per_nx;

  assign aligned = (paddr[1:0] == 2'b00);
  assign rsel    = wdt_reg_e'(paddr[3:2]);
  assign wr      = psel && pwrite && aligned;
  assign wr_ctrl = wr && (rsel == REG_CTRL);
  assign wr_per  = wr && (rsel == REG_PERIOD);
  assign wr_cnt  = wr && (rsel == REG_COUNT);
  assign kick    = wr && (rsel == REG_KICK) && pwdata[0];

  assign en_nx  = wr_ctrl ? pwdata[0] : en_sh;
  assign per_nx = wr_per  ? pwdata[DATA_W-1 -: PERIOD_W] : per_sh;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      en_sh  <= 1'b0;
      per_sh <= '0;
    end else begin
      en_sh  <= en_nx;
      per_sh <= per_nx;
    end
  end

  // Settings channel: full shadow snapshot, so coalesced writes stay coherent
  logic             cfg_fire;
  logic [CFG_W-1:0] cfg_data;
  wdt_xfer #(.W(CFG_W)) u_cfg_xfer (
    .rst_n    (rst_n),
    .src_clk  (bclk),
    .src_load (wr_ctrl || wr_per),
    .src_data ({en_nx, per_nx}),
    .dst_clk  (oclk),
    .dst_fire (cfg_fire),
    .dst_data (cfg_data)
  );

  // Zeroing channel: service writes and zero-valued count writes
  logic zero_fire, zero_do;
  wdt_xfer #(.W(1)) u_zero_xfer (
    .rst_n    (rst_n),
    .src_clk  (bclk),
    .src_load (wr_cnt || kick),
    .src_data (kick ? 1'b1 : (pwdata == '0)),
    .dst_clk  (oclk),
    .dst_fire (zero_fire),
    .dst_data (zero_do)
  );

  logic             ovf_tgl;
  logic [CNT_W-1:0] cnt_gray;
  wdt_osc_core #(.PERIOD_W(PERIOD_W), .PRE(PRESCALE_LOG2)) u_core (
    .clk        (oclk),
    .rst_n      (rst_n),
    .cfg_fire   (cfg_fire),
    .cfg_en     (cfg_data[CFG_W-1]),
    .cfg_period (cfg_data[PERIOD_W-1:0]),
    .zero_fire  (zero_fire),
    .zero_do    (zero_do),
    .ovf_tgl    (ovf_tgl),
    .cnt_gray   (cnt_gray)
  );

  wdt_stage u_stage (
    .clk        (bclk),
    .rst_n      (rst_n),
    .ovf_tgl_in (ovf_tgl),
    .kick       (kick),
    .irq        (irq),
    .rst_req    (rst_req)
  );

  // Gray-coded count snapshot into the bus domain
  logic [CNT_W-1:0] g1_q, g2_q, cnt_bin;
  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      g1_q <= '0;
      g2_q <= '0;
    end else begin
      g1_q <= cnt_gray;
      g2_q <= g1_q;
    end
  end

  always_comb begin
    for (int i = 0; i < CNT_W; i++) cnt_bin[i] = ^(g2_q >> i);
  end

  always_comb begin
    prdata = '0;
    if (aligned) begin
      case (rsel)
        REG_CTRL:   prdata = DATA_W'(en_sh);
        REG_PERIOD: prdata = {per_sh, {PLSB{1'b0}}};
        REG_COUNT:  prdata = DATA_W'(cnt_bin);
        REG_KICK:   prdata = DATA_W'(irq);
        default:    prdata = '0;
      endcase
    end
  end
endmodule

// File: tb/sim_wdt_twostage.sv
module sim_wdt_twostage;
  localparam int BUS_PERIOD = 10;
  localparam int OSC_PERIOD = 3 * BUS_PERIOD;
  localparam int PRE        = 4;

  logic        bclk = 1'b0, oclk = 1'b0, rst_n = 1'b0;
  logic        psel = 1'b0, pwrite = 1'b0;
  logic [3:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        irq, rst_req;

  int n_cmp = 0, n_bad = 0;
  bit run_cmp = 1'b0;

  wdt_twostage #(.PERIOD_W(12), .PRESCALE_LOG2(PRE), .DATA_W(32)) u0 (
    .bclk(bclk), .oclk(oclk), .rst_n(rst_n), .psel(psel), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq), .rst_req(rst_req)
  );

  initial forever #(BUS_PERIOD/2) bclk = ~bclk;
  initial begin
    #2;
    forever #(OSC_PERIOD/2) oclk = ~oclk;
  end

  // ---------------- reference model ----------------
  int     m_cfg_age = -1, m_zero_age = -1;
  bit     m_cfg_en, m_zero_do;
  int     m_cfg_per;
  bit     m_en;
  int     m_per;
  longint m_cnt;
  int     ovq[$];
  bit     m_irq, m_rst, sh_en;
  int     sh_per;

  always @(posedge oclk) begin
    if (!rst_n) begin
      m_en = 0; m_per = 0; m_cnt = 0;
    end else begin
      bit cfg_app, z_app;
      cfg_app = 0; z_app = 0;
      if (m_cfg_age >= 0) begin
        m_cfg_age++;
        if (m_cfg_age == 3) begin cfg_app = 1; m_cfg_age = -1; end
      end
      if (m_zero_age >= 0) begin
        m_zero_age++;
        if (m_zero_age == 3) begin z_app = 1; m_zero_age = -1; end
      end
      if (m_en) begin
        if (m_cnt == longint'(m_per + 1) * (64'd1 << PRE) - 1) begin
          m_cnt = 0;
          ovq.push_back(0);
        end else m_cnt++;
      end
      if (cfg_app) begin m_en = m_cfg_en; m_per = m_cfg_per; end
      if (z_app && m_zero_do) m_cnt = 0;
    end
  end

  always @(posedge bclk) begin
    if (!rst_n) begin
      ovq.delete(); m_irq = 0; m_rst = 0; sh_en = 0; sh_per = 0;
      m_cfg_age = -1; m_zero_age = -1;
    end else begin
      bit evt, w, kk;
      evt = 0;
      for (int i = 0; i < ovq.size(); i++) ovq[i]++;
      if (ovq.size() > 0 && ovq[0] >= 3) begin evt = 1; void'(ovq.pop_front()); end
      w  = psel && pwrite && (paddr[1:0] == 2'b00);
      kk = w && paddr[3:2] == 2'd3 && pwdata[0];
      if (evt) begin
        if (m_irq && !kk) m_rst = 1;
        m_irq = 1;
      end else if (kk) m_irq = 0;
      if (w && paddr[3:2] == 2'd0) begin
        sh_en = pwdata[0]; m_cfg_en = sh_en; m_cfg_per = sh_per; m_cfg_age = 0;
      end
      if (w && paddr[3:2] == 2'd1) begin
        sh_per = int'(pwdata[31:20]); m_cfg_en = sh_en; m_cfg_per = sh_per; m_cfg_age = 0;
      end
      if (w && paddr[3:2] == 2'd2) begin m_zero_do = (pwdata == 0); m_zero_age = 0; end
      if (kk) begin m_zero_do = 1; m_zero_age = 0; end
    end
  end

  // R4 R5 R8: outputs against the model on every bus cycle
  always @(negedge bclk) begin
    if (rst_n && run_cmp) begin
      n_cmp++;
      if (irq !== m_irq || rst_req !== m_rst) begin
        n_bad++;
        $display("FAIL R4 R5 R8 cycle compare at %0t: irq/rst act=%b%b exp=%b%b",
                 $time, irq, rst_req, m_irq, m_rst);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge bclk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge bclk);
    psel = 1; pwrite = 1; paddr = a; pwdata = d;
    @(negedge bclk);
    psel = 0; pwrite = 0; pwdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge bclk);
    psel = 1; pwrite = 0; paddr = a;
    #1 d = prdata;
    psel = 0;
  endtask

  task automatic do_reset();
    @(negedge bclk);
    rst_n = 0;
    idle(6);
    rst_n = 1;
    idle(2);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(longint'(BUS_PERIOD) * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d, held;
    idle(5);
    rst_n = 1;
    idle(2);
    run_cmp = 1;

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 rst_req", 32'(rst_req), 0);
    rd(4'h0, d); chk("R1 ctrl", d, 0);
    rd(4'h4, d); chk("R1 period", d, 0);
    rd(4'h8, d); chk("R1 count", d, 0);
    rd(4'hC, d); chk("R1 service", d, 0);

    // R2 field masking
    wr(4'h4, 32'hFFFF_FFFF); idle(12);
    rd(4'h4, d); chk("R2 all ones", d, 32'hFFF0_0000);
    wr(4'h4, 32'h001A_BCDE); idle(12);
    rd(4'h4, d); chk("R2 N=1", d, 32'h0010_0000);

    // R8: not counting yet two bus cycles after enable
    wr(4'h0, 32'h1); idle(1);
    rd(4'h8, d); chk("R8 count before crossing", d, 0);
    idle(10);
    rd(4'h0, d); chk("R3 ctrl readback", d, 1);

    // R3 R9 disable holds count
    idle(40);
    wr(4'h0, 32'h0); idle(20);
    rd(4'h8, d); chk("R3 R9 held count", d, 32'(m_cnt));
    held = d;
    idle(10);
    rd(4'h8, d); chk("R3 count stable", d, held);

    // R7 nonzero ignored, zero clears
    wr(4'h8, 32'h5); idle(20);
    rd(4'h8, d); chk("R7 nonzero ignored", d, held);
    wr(4'h8, 32'h0); idle(20);
    rd(4'h8, d); chk("R7 zeroed", d, 0);

    // R4 first overflow
    wr(4'h0, 32'h1); idle(120);
    chk("R4 irq set", 32'(irq), 1);
    rd(4'hC, d); chk("R4 service bit", d, 1);
    chk("R4 no reset yet", 32'(rst_req), 0);

    // R6 service behaviour
    wr(4'hC, 32'h0); idle(2);
    chk("R6 bit0 clear ignored", 32'(irq), 1);
    for (int k = 0; k < 4; k++) begin
      wr(4'hC, 32'h1);
      chk("R6 irq dropped", 32'(irq), 0);
      idle(48);
      chk("R6 no reset while serviced", 32'(rst_req), 0);
    end

    // R5 two unserviced periods
    idle(250);
    chk("R5 reset requested", 32'(rst_req), 1);
    wr(4'hC, 32'h1); idle(12);
    wr(4'h0, 32'h0); idle(20);
    chk("R5 reset sticky", 32'(rst_req), 1);

    do_reset();
    chk("R1 irq after reset", 32'(irq), 0);
    chk("R1 rst_req after reset", 32'(rst_req), 0);

    // R8 period change mid-run, shortest period first
    wr(4'h4, 32'h0); idle(12);
    wr(4'h0, 32'h1); idle(30);
    wr(4'h4, 32'h0020_0000); idle(300);
    chk("R8 R5 reset after new period", 32'(rst_req), 1);

    idle(4);
    summary();
    $finish;
  end
endmodule